// File: doc/BRIEF.md
# Dynamic Bus Sizing Transfer Sequencer

This block takes one internal operand request and turns it into a series of external bus cycles. The request is a byte, a word or a long word, with a 24-bit address and, for writes, 32 bits of data. The external port can be 8 or 16 bits wide. The block does not know the width in advance. It learns the width from the two-line acknowledge that ends each bus cycle. On every cycle it drives the current address and a two-bit code for the bytes still to move, and it places operand bytes on the data lanes. On reads it collects the returned bytes into a right-justified 32-bit result.

Operands are big-endian: the most significant byte goes to the lowest address and is moved first. A word or long-word request at an odd address is rejected with a one-cycle fault, and no bus cycle is started. The requester sees a ready signal. A done pulse carries the read result after the final cycle.

Top module: `dbs_seq`

## Requirements
- R1: After reset, req_ready_o is 1 and bus_cyc_o, done_o and fault_o are 0.
- R2: A request with size code 10 (word) or 00 (long) at an odd address, or with size code 11, raises fault_o for exactly the next cycle and starts no bus cycle. A byte request (01) is accepted at any address.
- R3: During each bus cycle, bus_siz_o holds the number of bytes still to transfer: 01 = one, 10 = two, 11 = three, 00 = four. A long word on an 8-bit port therefore shows 00, 11, 10, 01 in that order.
- R4: bus_ack_n_i = 2'b10 ends a cycle on an 8-bit port and 2'b00 ends it on a 16-bit port. Any other value is a wait state, during which bus_addr_o, bus_siz_o and bus_wdata_o stay unchanged.
- R5: After an acknowledged cycle the address advances by the bytes moved: 2 on a 16-bit port at an even address with at least two bytes left, and 1 in every other case.
- R6: On writes, bus_wdata_o[15:8] carries the next operand byte. bus_wdata_o[7:0] carries the byte after it when the address is even and at least two bytes remain; otherwise it carries a copy of the upper byte.
- R7: On reads, an 8-bit port delivers on bus_rdata_i[15:8]. A 16-bit port delivers even-address bytes on [15:8] and odd-address bytes on [7:0]. Lanes that carry no part of the operand are ignored. rdata_o holds the operand right-justified with zero fill, and it is zero after a write.
- R8: done_o pulses for one cycle, the cycle after the final acknowledge, with rdata_o valid in that same cycle.
- R9: req_ready_o is 0 from acceptance until the transfer ends. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Sequencer idle, request will be taken |
| req_size_i | input | 2 | Operand size: 01 byte, 10 word, 00 long |
| req_addr_i | input | 24 | Operand byte address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write operand, right-justified |
| bus_cyc_o | output | 1 | Bus cycle in progress |
| bus_we_o | output | 1 | Bus cycle direction |
| bus_addr_o | output | 24 | Current byte address |
| bus_siz_o | output | 2 | Bytes remaining code |
| bus_wdata_o | output | 16 | Write data lanes |
| bus_rdata_i | input | 16 | Read data lanes |
| bus_ack_n_i | input | 2 | Cycle acknowledge and port width |
| done_o | output | 1 | Transfer complete pulse |
| fault_o | output | 1 | Misaligned or illegal request pulse |
| rdata_o | output | 32 | Assembled read operand |

## Verification
The bench sweeps every size, both address parities, both port widths and both directions, with zero to two wait states. It computes expected addresses, size codes, lane contents and read results from a byte-addressed memory model. It targets the long word on an 8-bit port: a sequencer that mishandles the three-byte step shows 10 where 11 belongs, or advances the address by 2. It drives foreign bytes on unused lanes, so a design that takes the wrong lane returns a corrupted result. It also checks odd-address bytes on a 16-bit port, which move only one byte, and it presents requests while the sequencer is busy, which must not disturb the transfer.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int BYTE_W   = 8;
  localparam int OP_BYTES = 4;
  localparam int OP_W     = BYTE_W * OP_BYTES;
  localparam int LANE_W   = 2 * BYTE_W;
  localparam int CNT_W    = $clog2(OP_BYTES + 1);

  typedef enum logic [1:0] {
    SIZ_LONG = 2'b00,
    SIZ_BYTE = 2'b01,
    SIZ_WORD = 2'b10,
    SIZ_TRI  = 2'b11
  } siz_e;

  localparam logic [1:0] ACK_PORT8  = 2'b10;
  localparam logic [1:0] ACK_PORT16 = 2'b00;

  function automatic logic [CNT_W-1:0] siz_bytes(input logic [1:0] siz);
    return (siz == SIZ_LONG) ? CNT_W'(OP_BYTES) : CNT_W'(siz);
  endfunction
endpackage

// File: rtl/dbs_step.sv
module dbs_step
  import dbs_pkg::*;
(
  input  logic             a0_i,
  input  logic [CNT_W-1:0] rem_i,
  input  logic             ack8_i,
  input  logic             ack16_i,
  output logic [CNT_W-1:0] adv_o,
  output logic             hi_en_o,
  output logic             lo_en_o,
  output logic [1:0]       hi_idx_o,
  output logic [1:0]       lo_idx_o
);
  logic [CNT_W-1:0] rem_m1, rem_m2;
  logic             pair;

  assign rem_m1 = rem_i - CNT_W'(1);
  assign rem_m2 = rem_i - CNT_W'(2);
  assign pair   = !a0_i && (rem_i >= CNT_W'(2));

  always_comb begin
    adv_o = '0;
    if (ack8_i)       adv_o = CNT_W'(1);
    else if (ack16_i) adv_o = pair ? CNT_W'(2) : CNT_W'(1);
  end

  assign hi_en_o  = ack8_i || (ack16_i && !a0_i);
  assign lo_en_o  = ack16_i && (a0_i || pair);
  assign hi_idx_o = rem_m1[1:0];
  assign lo_idx_o = a0_i ? rem_m1[1:0] : rem_m2[1:0];
endmodule

// File: rtl/dbs_wlane.sv
module dbs_wlane
  import dbs_pkg::*;
(
  input  logic [OP_W-1:0]   wdata_i,
  input  logic [CNT_W-1:0]  rem_i,
  input  logic              a0_i,
  output logic [LANE_W-1:0] lanes_o
);
  logic [CNT_W-1:0]  rem_m1, rem_m2;
  logic [BYTE_W-1:0] cur_b, nxt_b;

  assign rem_m1 = rem_i - CNT_W'(1);
  assign rem_m2 = rem_i - CNT_W'(2);
  assign cur_b  = wdata_i[BYTE_W*rem_m1[1:0] +: BYTE_W];
  assign nxt_b  = wdata_i[BYTE_W*rem_m2[1:0] +: BYTE_W];
  // upper byte mirrored on lower lanes unless a pair goes out together
  assign lanes_o = {cur_b, (!a0_i && rem_i >= CNT_W'(2)) ? nxt_b : cur_b};
endmodule

// File: rtl/dbs_rpack.sv
module dbs_rpack
  import dbs_pkg::*;
(
  input  logic [OP_W-1:0]   cur_i,
  input  logic [LANE_W-1:0] lanes_i,
  input  logic              hi_en_i,
  input  logic              lo_en_i,
  input  logic [1:0]        hi_idx_i,
  input  logic [1:0]        lo_idx_i,
  output logic [OP_W-1:0]   nxt_o
);
  for (genvar k = 0; k < OP_BYTES; k++) begin : g_byte
    always_comb begin
      nxt_o[BYTE_W*k +: BYTE_W] = cur_i[BYTE_W*k +: BYTE_W];
      if (hi_en_i && hi_idx_i == 2'(k))
        nxt_o[BYTE_W*k +: BYTE_W] = lanes_i[LANE_W-1 -: BYTE_W];
      else if (lo_en_i && lo_idx_i == 2'(k))
        nxt_o[BYTE_W*k +: BYTE_W] = lanes_i[BYTE_W-1:0];
    end
  end
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [OP_W-1:0]   req_wdata_i,
  output logic              bus_cyc_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [1:0]        bus_siz_o,
  output logic [LANE_W-1:0] bus_wdata_o,
  input  logic [LANE_W-1:0] bus_rdata_i,
  input  logic [1:0]        bus_ack_n_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [OP_W-1:0]   rdata_o
);
  logic              busy_q, we_q, done_q, fault_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q, adv;
  logic [OP_W-1:0]   wdata_q, rbuf_q, rbuf_nxt, rdata_q;
  logic              ack8, ack16, hi_en, lo_en, misalign;
  logic [1:0]        hi_idx, lo_idx;

  assign ack8     = busy_q && (bus_ack_n_i == ACK_PORT8);
  assign ack16    = busy_q && (bus_ack_n_i == ACK_PORT16);
  assign misalign = (req_size_i == SIZ_TRI) ||
                    (req_size_i != SIZ_BYTE && req_addr_i[0]);

  dbs_step u_step (
    .a0_i    (addr_q[0]),
    .rem_i   (rem_q),
    .ack8_i  (ack8),
    .ack16_i (ack16),
    .adv_o   (adv),
    .hi_en_o (hi_en),
    .lo_en_o (lo_en),
    .hi_idx_o(hi_idx),
    .lo_idx_o(lo_idx)
  );

  dbs_wlane u_wlane (
    .wdata_i(wdata_q),
    .rem_i  (rem_q),
    .a0_i   (addr_q[0]),
    .lanes_o(bus_wdata_o)
  );

  dbs_rpack u_rpack (
    .cur_i   (rbuf_q),
    .lanes_i (bus_rdata_i),
    .hi_en_i (hi_en && !we_q),
    .lo_en_i (lo_en && !we_q),
    .hi_idx_i(hi_idx),
    .lo_idx_i(lo_idx),
    .nxt_o   (rbuf_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      addr_q  <= '0;
      rem_q   <= '0;
      wdata_q <= '0;
      rbuf_q  <= '0;
      rdata_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i) begin
          if (misalign) begin
            fault_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            we_q    <= req_we_i;
            addr_q  <= req_addr_i;
            rem_q   <= siz_bytes(req_size_i);
            wdata_q <= req_wdata_i;
            rbuf_q  <= '0;
          end
        end
      end else if (adv != '0) begin
        addr_q <= addr_q + ADDR_W'(adv);
        rem_q  <= rem_q - adv;
        rbuf_q <= rbuf_nxt;
        if (rem_q == adv) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          rdata_q <= rbuf_nxt;
        end
      end
    end
  end

  assign req_ready_o = !busy_q;
  assign bus_cyc_o   = busy_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_siz_o   = rem_q[1:0];
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign rdata_o     = rdata_q;

  AST_READY_LOW_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_cyc_o |-> !req_ready_o); // R9
  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_cyc_o && !ack8 && !ack16) |=> (bus_cyc_o && $stable(bus_addr_o) &&
      $stable(bus_siz_o) && $stable(bus_wdata_o))); // R4
  AST_FAULT_NO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!bus_cyc_o && !done_o)); // R2
  AST_DONE_AFTER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(bus_cyc_o)); // R8
  AST_STEP_PORT8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack8 && bus_siz_o != SIZ_BYTE) |=> (bus_addr_o == $past(bus_addr_o) + 1'b1)); // R5
  AST_LANES_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_en && lo_en) |-> (hi_idx != lo_idx)); // R7
endmodule

// File: tb/dbs_seq_tb_top.sv
module dbs_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [1:0]  req_size_i = 2'b01;
  logic [23:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [15:0] bus_rdata_i = '0;
  logic [1:0]  bus_ack_n_i = 2'b11;
  logic        req_ready_o, bus_cyc_o, bus_we_o, done_o, fault_o;
  logic [23:0] bus_addr_o;
  logic [1:0]  bus_siz_o;
  logic [15:0] bus_wdata_o;
  logic [31:0] rdata_o;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dbs_seq dut_i (.*);

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return 8'((a * 7 + 24'h5B) ^ (a >> 5));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_fault(input logic [1:0] siz, input logic [23:0] addr);
    @(negedge clk_i);
    req_size_i = siz; req_addr_i = addr; req_we_i = 1'b0; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(fault_o == 1'b1, "R2", "fault raised", 32'(fault_o), 1);
    chk(bus_cyc_o == 1'b0, "R2", "no cycle on fault", 32'(bus_cyc_o), 0);
    @(negedge clk_i);
    chk(fault_o == 1'b0, "R2", "fault single pulse", 32'(fault_o), 0);
    chk(bus_cyc_o == 1'b0 && req_ready_o, "R2", "idle after fault", 32'(bus_cyc_o), 0);
  endtask

  task automatic run_xfer(input logic [1:0] siz, input logic [23:0] addr, input bit we,
                          input bit port16, input int waits, input logic [31:0] wd,
                          input bit poke);
    int n, rem;
    logic [23:0] a;
    logic [31:0] res;
    logic [7:0]  ub, lb;
    n = (siz == 2'b00) ? 4 : int'(siz);
    res = '0;
    for (int i = 0; i < n; i++) res = (res << 8) | 32'(mem_byte(addr + 24'(i)));
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R9", "ready before request", 32'(req_ready_o), 1);
    req_size_i = siz; req_addr_i = addr; req_we_i = we; req_wdata_i = wd; req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    a = addr; rem = n;
    while (rem > 0) begin
      chk(bus_cyc_o == 1'b1, "R9", "cycle active", 32'(bus_cyc_o), 1);
      chk(req_ready_o == 1'b0, "R9", "ready low while busy", 32'(req_ready_o), 0);
      chk(bus_addr_o == a, "R5", "address", 32'(bus_addr_o), 32'(a));
      chk(bus_siz_o == 2'(rem), "R3", "size code", 32'(bus_siz_o), 32'(rem & 3));
      if (we) begin
        ub = wd[8*(rem-1) +: 8];
        lb = (!a[0] && rem >= 2) ? wd[8*(rem-2) +: 8] : ub;
        chk(bus_wdata_o == {ub, lb}, "R6", "write lanes", 32'(bus_wdata_o), 32'({ub, lb}));
      end
      for (int w = 0; w < waits; w++) begin
        bus_ack_n_i = (w == 1) ? 2'b01 : 2'b11;
        if (poke && w == 0) begin
          req_addr_i = addr ^ 24'h000400; req_size_i = 2'b01; req_valid_i = 1'b1;
        end
        @(negedge clk_i);
        req_valid_i = 1'b0;
        chk(bus_addr_o == a && bus_siz_o == 2'(rem), "R4", "hold during wait",
            32'(bus_addr_o), 32'(a));
        if (we) chk(bus_wdata_o == {ub, lb}, "R4", "wdata hold during wait",
                    32'(bus_wdata_o), 32'({ub, lb}));
      end
      bus_ack_n_i = port16 ? 2'b00 : 2'b10;
      bus_rdata_i = port16 ? {mem_byte({a[23:1], 1'b0}), mem_byte({a[23:1], 1'b1})}
                           : {mem_byte(a), 8'hC3};
      @(negedge clk_i);
      bus_ack_n_i = 2'b11;
      bus_rdata_i = 16'hDEAD;
      if (port16 && !a[0] && rem >= 2) begin a = a + 24'd2; rem = rem - 2; end
      else begin a = a + 24'd1; rem = rem - 1; end
    end
    chk(done_o == 1'b1, "R8", "done after last ack", 32'(done_o), 1);
    chk(bus_cyc_o == 1'b0, "R8", "cycle ends", 32'(bus_cyc_o), 0);
    chk(rdata_o == (we ? 32'h0 : res), "R7", "assembled result", rdata_o, we ? 32'h0 : res);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8", "done single pulse", 32'(done_o), 0);
    chk(bus_cyc_o == 1'b0 && req_ready_o, "R9", "busy request ignored", 32'(bus_cyc_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int iter;
    logic [1:0] sizes [3];
    sizes[0] = 2'b01; sizes[1] = 2'b10; sizes[2] = 2'b00;
    iter = 0;
    #(CLK_PERIOD * 2 + 1);
    chk(req_ready_o == 1'b1, "R1", "ready in reset", 32'(req_ready_o), 1);
    chk(!bus_cyc_o && !done_o && !fault_o, "R1", "outputs idle in reset",
        32'({bus_cyc_o, done_o, fault_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !bus_cyc_o, "R1", "idle after reset", 32'(bus_cyc_o), 0);
    for (int s = 0; s < 3; s++)
      for (int odd = 0; odd < 2; odd++)
        for (int p = 0; p < 2; p++)
          for (int we = 0; we < 2; we++) begin
            logic [23:0] ad;
            ad = 24'h0A3520 + 24'(iter * 6) + 24'(odd);
            iter++;
            if (sizes[s] != 2'b01 && odd == 1) run_fault(sizes[s], ad);
            else run_xfer(sizes[s], ad, we[0], p[0], iter % 3,
                          32'hF1E2D3C4 ^ 32'(iter * 32'h01010101), iter % 2 == 0);
          end
    run_fault(2'b11, 24'h000100);
    run_xfer(2'b00, 24'hFFFFF0, 1'b0, 1'b0, 2, 32'h0, 1'b1);
    run_xfer(2'b00, 24'h000202, 1'b1, 1'b1, 0, 32'h11223344, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule